// File: doc/BRIEF.md
# Debug Command Executor

This block sits between a host-side command interface and the system bus and carries out debug commands while the processor keeps running. The host presents an 8-bit opcode, together with a 16-bit address where the opcode needs one, for a single cycle. The block then reads memory on the bus, or reads its own small bank of debug registers, or records a request for the processor to enter background mode. Read results come back as a 16-bit word with a one-cycle valid pulse.

Memory reads take bus cycles from the processor. An access that the bus finishes in its first cycle goes unnoticed. A longer access drops the processor's clock enable until the bus acknowledges. After each accepted command the block stays busy for a fixed hold time, and the host must not issue again until busy falls. A debug register window can be laid over the top of memory. Byte reads put their byte in the half of the result that the address parity selects.

Top module: `dbg_cmd_exec`

## Requirements
- R1: A command is taken in a cycle where `cmd_valid_i` is high, `busy_o` is low and the opcode is one of the known codes: 0x90 (background request), 0xE0 (byte read, window hidden), 0xE4 (byte read, window visible), 0xEC (word read, window visible).
- R2: Once a command is taken, `busy_o` is high from the next cycle on for `BUSY_CYC` cycles, and also for as long as the resulting bus access is open.
- R3: A command presented while `busy_o` is high is dropped and gives a one-cycle `cmd_rej_o` pulse in the next cycle.
- R4: An opcode outside the four known codes has no effect: `busy_o` stays low, no bus request is made and no read data is returned.
- R5: Opcode 0x90 taken while `fw_en_i` is high raises `bgnd_req_o` in the next cycle. Taken while `fw_en_i` is low, it leaves `bgnd_req_o` low.
- R6: While `bgnd_req_o` is high, a cycle with `insn_boundary_i` high gives a one-cycle `enter_bg_o` pulse in the next cycle and clears `bgnd_req_o`.
- R7: The status register at window offset 1 (address 0xFF01) tracks the inputs with one cycle of delay: 0xC0 when `bg_active_i` is high, otherwise 0x00 when `bgnd_insn_en_i` is high and 0x80 when it is low. It resets to 0x80.
- R8: A 0xE4 or 0xEC read whose address falls in 0xFF00..0xFF06 is served from the window with no bus request, and `rd_valid_o` pulses in the next cycle. Window bytes other than offset 1 read 0x00, and the byte after the window in a word read at 0xFF06 reads 0x00.
- R9: A 0xE0 read always goes to the bus, including inside the window range. So does a 0xE4 read at 0xFF07.
- R10: A byte read returns the byte of an odd address in bits 7:0 and the byte of an even address in bits 15:8, with the other half zero. A bus word holds the even-address byte in bits 15:8.
- R11: A 0xEC read at an odd address makes no bus request and gives a one-cycle `align_err_o` pulse in the next cycle.
- R12: A bus read raises `mem_req_o` in the cycle after the command is taken, with `mem_addr_o` word-aligned (bit 0 clear). Both hold until the cycle in which `mem_ack_i` is high. `rd_valid_o` pulses in the cycle after that.
- R13: `cpu_clk_en_o` is low from the second cycle of a bus access up to and including its acknowledge cycle. It is high at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 8 | Command opcode |
| cmd_addr_i | input | 16 | Command address |
| fw_en_i | input | 1 | Background firmware enabled |
| bg_active_i | input | 1 | Processor is in background mode |
| bgnd_insn_en_i | input | 1 | Background instruction allowed in user code |
| insn_boundary_i | input | 1 | Processor is at an instruction boundary |
| mem_ack_i | input | 1 | Bus access completes this cycle |
| mem_rdata_i | input | 16 | Bus read word, valid with ack |
| busy_o | output | 1 | Host must hold off |
| cmd_rej_o | output | 1 | Command dropped because busy |
| align_err_o | output | 1 | Misaligned word read |
| rd_valid_o | output | 1 | Read result valid |
| rd_data_o | output | 16 | Read result |
| bgnd_req_o | output | 1 | Background entry pending |
| enter_bg_o | output | 1 | Enter background mode now |
| mem_req_o | output | 1 | Bus read request |
| mem_addr_o | output | 16 | Bus word address |
| cpu_clk_en_o | output | 1 | Processor clock enable |

## Verification
The bench builds the block with `BUSY_CYC` = 24 and leaves the window at seven registers based at 0xFF00. The short hold time lets one run hold `cmd_valid_i` across the whole busy window, so it covers both a rejection in the last busy cycle and an acceptance in the first free one. It also lets the run cover many read shapes: bus latencies from zero to six cycles, both byte parities, both window edges and every status encoding. The memory model responds with a latency that each test picks.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
   localparam logic [7:0] OP_BGND     = 8'h90;
   localparam logic [7:0] OP_RB_MEM   = 8'hE0;
   localparam logic [7:0] OP_RB_WIN   = 8'hE4;
   localparam logic [7:0] OP_RW_WIN   = 8'hEC;

   localparam logic [7:0] STAT_BG     = 8'hC0;
   localparam logic [7:0] STAT_OPEN   = 8'h00;
   localparam logic [7:0] STAT_LOCKED = 8'h80;

   typedef enum logic {ST_IDLE, ST_BUS} exec_st_t;

   function automatic logic op_known(input logic [7:0] op);
      return (op == OP_BGND) || (op == OP_RB_MEM) ||
             (op == OP_RB_WIN) || (op == OP_RW_WIN);
   endfunction

   // even-address byte lives in the high half of a word
   function automatic logic [15:0] place_data(input logic word, input logic odd,
                                              input logic [15:0] w);
      if (word)     return w;
      else if (odd) return {8'h00, w[7:0]};
      else          return {w[15:8], 8'h00};
   endfunction
endpackage

// File: rtl/dbg_hold_timer.sv
module dbg_hold_timer #(
   parameter int CYC = 150
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o
);
   localparam int CW = $clog2(CYC + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt_q <= '0;
      else if (start_i)    cnt_q <= CW'(CYC);
      else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != 0);

   // R2
   hold_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> busy_o);
endmodule

// File: rtl/dbg_win_regs.sv
module dbg_win_regs #(
   parameter int             AW       = 16,
   parameter logic [AW-1:0]  BASE     = 16'hFF00,
   parameter int             N_REGS   = 7,
   parameter int             STAT_IDX = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bg_active_i,
   input  logic          insn_en_i,
   input  logic          word_i,
   input  logic [AW-1:0] addr_i,
   output logic          hit_o,
   output logic [15:0]   data_o
);
   import dbg_pkg::*;
   localparam int OW = $clog2(N_REGS + 1);

   logic [7:0]    status_q;
   logic [7:0]    bank [N_REGS+1];
   logic [AW-1:0] off;
   logic [OW-1:0] idx, idx_nx;

   always_ff @(posedge clk) begin
      if (!rst_n)           status_q <= STAT_LOCKED;
      else if (bg_active_i) status_q <= STAT_BG;
      else if (insn_en_i)   status_q <= STAT_OPEN;
      else                  status_q <= STAT_LOCKED;
   end

   for (genvar i = 0; i <= N_REGS; i++) begin : g_bank
      if (i == STAT_IDX) begin : g_stat
         assign bank[i] = status_q;
      end else begin : g_zero
         assign bank[i] = 8'h00;
      end
   end

   assign off    = addr_i - BASE;
   assign hit_o  = (addr_i >= BASE) && (off < AW'(N_REGS));
   assign idx    = off[OW-1:0];
   assign idx_nx = idx + 1'b1;

   always_comb begin
      if (word_i)       data_o = {bank[idx], bank[idx_nx]};
      else if (off[0])  data_o = {8'h00, bank[idx]};
      else              data_o = {bank[idx], 8'h00};
   end

   // R7
   stat_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q == STAT_BG) || (status_q == STAT_OPEN) || (status_q == STAT_LOCKED));
endmodule

// File: rtl/dbg_bgnd_ctl.sv
module dbg_bgnd_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic boundary_i,
   output logic pend_o,
   output logic enter_o
);
   logic pend_q, enter_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         enter_q <= 1'b0;
      end else begin
         enter_q <= pend_q && boundary_i;
         pend_q  <= (pend_q && !boundary_i) || set_i;
      end
   end

   assign pend_o  = pend_q;
   assign enter_o = enter_q;

   // R6
   enter_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q && boundary_i && !set_i |=> enter_o && !pend_o);
endmodule

// File: rtl/dbg_cmd_exec.sv
module dbg_cmd_exec #(
   parameter int            AW       = 16,
   parameter int            BUSY_CYC = 150,
   parameter logic [AW-1:0] WIN_BASE = 16'hFF00,
   parameter int            WIN_REGS = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid_i,
   input  logic [7:0]    cmd_op_i,
   input  logic [AW-1:0] cmd_addr_i,
   input  logic          fw_en_i,
   input  logic          bg_active_i,
   input  logic          bgnd_insn_en_i,
   input  logic          insn_boundary_i,
   input  logic          mem_ack_i,
   input  logic [15:0]   mem_rdata_i,
   output logic          busy_o,
   output logic          cmd_rej_o,
   output logic          align_err_o,
   output logic          rd_valid_o,
   output logic [15:0]   rd_data_o,
   output logic          bgnd_req_o,
   output logic          enter_bg_o,
   output logic          mem_req_o,
   output logic [AW-1:0] mem_addr_o,
   output logic          cpu_clk_en_o
);
   import dbg_pkg::*;

   if (BUSY_CYC < 2) begin : g_bad_busy
      $error("BUSY_CYC must be at least 2");
   end
   if (WIN_REGS < 2) begin : g_bad_win
      $error("WIN_REGS must cover the status register");
   end

   exec_st_t      st_q;
   logic          first_q, word_q, odd_q;
   logic [AW-1:0] addr_q;
   logic          rej_q, aerr_q, rdv_q;
   logic [15:0]   rdata_q;
   logic          tmr_busy, take, is_read, op_word, op_win;
   logic          win_hit;
   logic [15:0]   win_data;

   assign busy_o  = tmr_busy || (st_q == ST_BUS);
   assign take    = cmd_valid_i && !busy_o && op_known(cmd_op_i);
   assign is_read = take && (cmd_op_i != OP_BGND);
   assign op_word = (cmd_op_i == OP_RW_WIN);
   assign op_win  = (cmd_op_i == OP_RB_WIN) || op_word;

   dbg_hold_timer #(.CYC(BUSY_CYC)) u_tmr (
      .clk(clk), .rst_n(rst_n), .start_i(take), .busy_o(tmr_busy));

   dbg_win_regs #(.AW(AW), .BASE(WIN_BASE), .N_REGS(WIN_REGS), .STAT_IDX(1)) u_win (
      .clk(clk), .rst_n(rst_n), .bg_active_i(bg_active_i), .insn_en_i(bgnd_insn_en_i),
      .word_i(op_word), .addr_i(cmd_addr_i), .hit_o(win_hit), .data_o(win_data));

   dbg_bgnd_ctl u_bg (
      .clk(clk), .rst_n(rst_n),
      .set_i(take && (cmd_op_i == OP_BGND) && fw_en_i),
      .boundary_i(insn_boundary_i), .pend_o(bgnd_req_o), .enter_o(enter_bg_o));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         first_q <= 1'b0;
         word_q  <= 1'b0;
         odd_q   <= 1'b0;
         addr_q  <= '0;
         rej_q   <= 1'b0;
         aerr_q  <= 1'b0;
         rdv_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         rej_q  <= cmd_valid_i && busy_o;
         aerr_q <= 1'b0;
         rdv_q  <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (is_read) begin
                  if (op_word && cmd_addr_i[0]) begin
                     aerr_q <= 1'b1;
                  end else if (op_win && win_hit) begin
                     rdv_q   <= 1'b1;
                     rdata_q <= win_data;
                  end else begin
                     st_q    <= ST_BUS;
                     first_q <= 1'b1;
                     word_q  <= op_word;
                     odd_q   <= cmd_addr_i[0];
                     addr_q  <= {cmd_addr_i[AW-1:1], 1'b0};
                  end
               end
            end
            ST_BUS: begin
               first_q <= 1'b0;
               if (mem_ack_i) begin
                  rdv_q   <= 1'b1;
                  rdata_q <= place_data(word_q, odd_q, mem_rdata_i);
                  st_q    <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign cmd_rej_o    = rej_q;
   assign align_err_o  = aerr_q;
   assign rd_valid_o   = rdv_q;
   assign rd_data_o    = rdata_q;
   assign mem_req_o    = (st_q == ST_BUS);
   assign mem_addr_o   = addr_q;
   assign cpu_clk_en_o = !((st_q == ST_BUS) && !first_q);

   // R3
   rej_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_i && busy_o |=> cmd_rej_o);
   // R12
   bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));
   // R12
   bus_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> !mem_addr_o[0]);
   // R13
   clk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && !mem_ack_i |=> !cpu_clk_en_o);
   // R11
   align_nobus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      align_err_o |-> !mem_req_o);
   // R5
   req_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bgnd_req_o) |-> $past(cmd_valid_i && (cmd_op_i == OP_BGND) && fw_en_i));
   // R4
   unknown_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_i && !busy_o && !op_known(cmd_op_i) |=> !busy_o);
endmodule

// File: tb/dbg_cmd_exec_tb.sv
module dbg_cmd_exec_tb_top;
   localparam int BUSY = 24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [7:0]  cmd_op = 8'h00;
   logic [15:0] cmd_addr = 16'h0000;
   logic        fw_en = 1'b0, bg_active = 1'b0, insn_en = 1'b0, boundary = 1'b0;
   logic        mem_ack = 1'b0;
   logic [15:0] mem_rdata = 16'h0000;
   logic        busy_o, cmd_rej_o, align_err_o, rd_valid_o, bgnd_req_o, enter_bg_o;
   logic        mem_req_o, cpu_clk_en_o;
   logic [15:0] rd_data_o, mem_addr_o;

   int checks = 0, errors = 0, lat = 0, wcnt = 0, cyc = 0;

   always #5 clk = ~clk;

   dbg_cmd_exec #(.BUSY_CYC(BUSY)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
      .cmd_addr_i(cmd_addr), .fw_en_i(fw_en), .bg_active_i(bg_active),
      .bgnd_insn_en_i(insn_en), .insn_boundary_i(boundary), .mem_ack_i(mem_ack),
      .mem_rdata_i(mem_rdata), .busy_o(busy_o), .cmd_rej_o(cmd_rej_o),
      .align_err_o(align_err_o), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
      .bgnd_req_o(bgnd_req_o), .enter_bg_o(enter_bg_o), .mem_req_o(mem_req_o),
      .mem_addr_o(mem_addr_o), .cpu_clk_en_o(cpu_clk_en_o));

   function automatic logic [15:0] mem_word(input logic [15:0] a);
      return a ^ 16'h5AC3;
   endfunction

   // reference model state
   int          m_cnt;
   logic        m_bus, m_first, m_word, m_odd, m_rej, m_aerr, m_rdv, m_pend, m_enter;
   logic [15:0] m_addr, m_rdata;
   logic [7:0]  m_status;

   function automatic logic [7:0] wbyte(input int i, input logic [7:0] st);
      return (i == 1) ? st : 8'h00;
   endfunction

   always @(posedge clk) begin
      logic ob, acc, op_pend;
      logic [7:0] ost;
      int o;
      if (!rst_n) begin
         m_cnt = 0; m_bus = 0; m_first = 0; m_word = 0; m_odd = 0; m_rej = 0;
         m_aerr = 0; m_rdv = 0; m_pend = 0; m_enter = 0; m_addr = 0; m_rdata = 0;
         m_status = 8'h80;
      end else begin
         ob  = (m_cnt != 0) || m_bus;
         ost = m_status;
         op_pend = m_pend;
         acc = cmd_valid && !ob && (cmd_op == 8'h90 || cmd_op == 8'hE0 ||
                                    cmd_op == 8'hE4 || cmd_op == 8'hEC);
         m_rej   = cmd_valid && ob;
         m_enter = op_pend && boundary;
         m_pend  = (op_pend && !boundary) || (acc && cmd_op == 8'h90 && fw_en);
         m_status = bg_active ? 8'hC0 : (insn_en ? 8'h00 : 8'h80);
         m_cnt   = acc ? BUSY : (m_cnt > 0 ? m_cnt - 1 : 0);
         m_rdv = 0; m_aerr = 0;
         if (m_bus) begin
            if (mem_ack) begin
               m_rdv = 1; m_bus = 0;
               m_rdata = m_word ? mem_rdata :
                         (m_odd ? {8'h00, mem_rdata[7:0]} : {mem_rdata[15:8], 8'h00});
            end else m_first = 0;
         end else if (acc && cmd_op != 8'h90) begin
            o = int'(cmd_addr) - 32'hFF00;
            if (cmd_op == 8'hEC && cmd_addr[0]) m_aerr = 1;
            else if ((cmd_op == 8'hE4 || cmd_op == 8'hEC) && o >= 0 && o <= 6) begin
               m_rdv = 1;
               if (cmd_op == 8'hEC) m_rdata = {wbyte(o, ost), wbyte(o + 1, ost)};
               else if (cmd_addr[0]) m_rdata = {8'h00, wbyte(o, ost)};
               else m_rdata = {wbyte(o, ost), 8'h00};
            end else begin
               m_bus = 1; m_first = 1; m_word = (cmd_op == 8'hEC);
               m_odd = cmd_addr[0]; m_addr = {cmd_addr[15:1], 1'b0};
            end
         end
      end
   end

   task automatic chk(input logic ok, input string tag, input logic [15:0] act,
                      input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   // compare every cycle, away from the clock edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk(busy_o == ((m_cnt != 0) || m_bus), "R2 busy", 16'(busy_o), 16'((m_cnt != 0) || m_bus));
         chk(cmd_rej_o == m_rej, "R3 reject", 16'(cmd_rej_o), 16'(m_rej));
         chk(align_err_o == m_aerr, "R11 align", 16'(align_err_o), 16'(m_aerr));
         chk(rd_valid_o == m_rdv, "R8 rd_valid", 16'(rd_valid_o), 16'(m_rdv));
         chk(rd_data_o == m_rdata, "R10 rd_data", rd_data_o, m_rdata);
         chk(bgnd_req_o == m_pend, "R5 bgnd_req", 16'(bgnd_req_o), 16'(m_pend));
         chk(enter_bg_o == m_enter, "R6 enter_bg", 16'(enter_bg_o), 16'(m_enter));
         chk(mem_req_o == m_bus, "R12 mem_req", 16'(mem_req_o), 16'(m_bus));
         if (m_bus) chk(mem_addr_o == m_addr, "R12 mem_addr", mem_addr_o, m_addr);
         chk(cpu_clk_en_o == !(m_bus && !m_first), "R13 clk_en",
             16'(cpu_clk_en_o), 16'(!(m_bus && !m_first)));
      end
   end

   // memory model with chosen latency
   always @(negedge clk) begin
      if (mem_req_o) begin
         mem_ack   = (wcnt == lat);
         mem_rdata = mem_ack ? mem_word(mem_addr_o) : 16'hBEEF;
         wcnt      = mem_ack ? 0 : wcnt + 1;
      end else begin
         mem_ack = 0; mem_rdata = 16'hBEEF; wcnt = 0;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic issue(input logic [7:0] op, input logic [15:0] a);
      @(negedge clk);
      cmd_valid = 1; cmd_op = op; cmd_addr = a;
      @(negedge clk);
      cmd_valid = 0;
   endtask

   task automatic settle();
      while (busy_o) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic run(input logic [7:0] op, input logic [15:0] a, input int l);
      lat = l;
      issue(op, a);
      settle();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // reset state
      chk(!busy_o && !mem_req_o && cpu_clk_en_o && !bgnd_req_o, "R1 reset idle",
          {busy_o, mem_req_o, cpu_clk_en_o, bgnd_req_o}, 16'h0002);
      // R7 R8 window reads under each status code
      run(8'hE4, 16'hFF01, 0);
      run(8'hE4, 16'hFF00, 0);
      run(8'hEC, 16'hFF00, 0);
      insn_en = 1; repeat (2) @(negedge clk);
      run(8'hEC, 16'hFF00, 0);
      bg_active = 1; repeat (2) @(negedge clk);
      run(8'hE4, 16'hFF01, 0);
      run(8'hEC, 16'hFF06, 0);
      run(8'hE4, 16'hFF06, 0);
      // R9 hidden window and just past the window
      run(8'hE0, 16'hFF01, 2);
      run(8'hE4, 16'hFF07, 0);
      run(8'hE4, 16'hFEFF, 1);
      // R10 byte placement, R12 R13 latencies
      run(8'hE0, 16'h1234, 0);
      run(8'hE0, 16'h1235, 3);
      run(8'hE4, 16'h0777, 1);
      run(8'hEC, 16'h2000, 0);
      run(8'hEC, 16'h2002, 1);
      run(8'hEC, 16'h4440, 6);
      // R11 misaligned word
      run(8'hEC, 16'h2001, 0);
      run(8'hEC, 16'hFF01, 0);
      // R3 rejection mid window
      lat = 0;
      issue(8'hE0, 16'h0100);
      repeat (2) @(negedge clk);
      issue(8'hE0, 16'h0200);
      settle();
      // R2 hold valid across the whole busy window and past it
      cmd_valid = 1; cmd_op = 8'hE0; cmd_addr = 16'h0300; lat = 2;
      repeat (BUSY + 8) @(negedge clk);
      cmd_valid = 0;
      settle();
      // R4 unknown opcodes
      run(8'h55, 16'h1000, 0);
      run(8'hE8, 16'h1000, 0);
      run(8'h00, 16'hFF01, 0);
      chk(!busy_o && !mem_req_o, "R4 unknown ignored", {busy_o, mem_req_o}, 16'h0000);
      // R5 background request gated by firmware enable
      run(8'h90, 16'h0000, 0);
      fw_en = 1;
      run(8'h90, 16'h0000, 0);
      repeat (3) @(negedge clk);
      // R6 boundary takes the request
      boundary = 1; @(negedge clk); boundary = 0;
      repeat (3) @(negedge clk);
      // R6 request and boundary in the same command cycle
      issue(8'h90, 16'h0000);
      boundary = 1; @(negedge clk); boundary = 0;
      settle();
      repeat (4) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule